// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the device side of a parallel flash bus. It watches the host's write cycles, each already latched and presented as a one-clock valid beat carrying an address and a data word. It recognises the multi-write unlock sequences that ask the flash to program a location, erase one sector, erase the whole chip, enter or leave the identification (autoselect) mode, or go back to plain reads. The block does not touch the memory array itself. When a sequence completes, it raises a one-cycle start pulse towards the execution engine, with the target address and data on the side. The engine reports back through a plain `busy` level.

Each sequence starts with a pair of unlock writes to two fixed key addresses. The key addresses depend on the bus width. In word mode they are 5555h then 2AAAh. In byte mode they are AAAAh then 5555h. A third write to the first key selects the command. Program takes one more write with the target. Erase takes a second unlock pair and a final command write. There is no dedicated reset: any write that breaks a sequence drops the decoder back to idle. A lock input guards a 16 KiB boot region at the bottom or the top of the address space, chosen by parameter.

The write input is a valid-only stream with no back-pressure. Every beat is consumed in the cycle it is presented, so the host may issue a beat on every clock. The start pulses are plain one-cycle strobes and are not held for a ready signal.

Top module: `flcmd_decoder`

## Requirements
- R1: After reset all three start pulses are low and the autoselect flag is low.
- R2: In word mode the beats AAh@5555h, 55h@2AAAh, A0h@5555h followed by a fourth beat (A, D) give `prog_start` high for exactly the cycle after the fourth beat, with `op_addr`=A and `op_data`=D.
- R3: In byte mode (`byte_mode`=1) the two key addresses are AAAAh and 5555h. In word mode a beat to AAAAh is not a valid first key. Keys are matched on the low 16 address bits, and command codes on the low 8 data bits.
- R4: The beats AAh@K1, 55h@K2, 80h@K1, AAh@K1, 55h@K2 followed by 30h at any address A give `serase_start` the cycle after the sixth beat, with `op_addr`=A.
- R5: The same five beats followed by 10h@K1 give `cerase_start` the cycle after the sixth beat.
- R6: The beats AAh@K1, 55h@K2, 90h@K1 set `autosel`. It stays set through the beats of a sequence still in progress. It clears on any accepted beat that ends a sequence, for example a single F0h write at any address or the last beat of a program.
- R7: A beat that does not match the expected step returns the decoder to idle. The beats that follow produce no start pulse until a full sequence is issued again from the first key.
- R8: While `busy` is high, beats are ignored and any partial sequence is abandoned. No start pulse follows a cycle in which `busy` was high.
- R9: With `boot_lock`=1, a program or sector-erase request whose byte address falls in the boot region is dropped without a pulse. With the default bottom placement the boot region is byte addresses below 4000h, which is word addresses below 2000h. The same request just outside the region still starts.
- R10: With `boot_lock`=1 a chip-erase sequence is dropped.
- R11: At most one start pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle host write beat |
| wr_addr | input | ADDR_W | Latched write address (word or byte address) |
| wr_data | input | DATA_W | Latched write data |
| byte_mode | input | 1 | 1 = byte bus, 0 = word bus |
| busy | input | 1 | Execution engine is running an operation |
| boot_lock | input | 1 | Boot region protection enable |
| prog_start | output | 1 | Start program pulse |
| serase_start | output | 1 | Start sector erase pulse |
| cerase_start | output | 1 | Start chip erase pulse |
| op_addr | output | ADDR_W | Target address of the last started operation |
| op_data | output | DATA_W | Data of the last started operation |
| autosel | output | 1 | Identification mode active |

## Verification
The hardest state to reach from the ports is a partial sequence that gets abandoned by `busy` without any write arriving during the busy cycle. The stimulus gets there by issuing three valid beats, raising `busy` for a single idle cycle, dropping it, and then sending the program data beat. No pulse may follow. The lock boundary is also approached from both sides, in word mode and in byte mode, so that the word-to-byte address scaling is exercised exactly at the edge of the region.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PGM, ST_ERA3, ST_ERA4, ST_ERA5
  } seq_state_t;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_IDENT    = 8'h90;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] WORD_KEY1 = 16'h5555;
  localparam logic [KEY_W-1:0] WORD_KEY2 = 16'h2AAA;
  localparam logic [KEY_W-1:0] BYTE_KEY1 = 16'hAAAA;
  localparam logic [KEY_W-1:0] BYTE_KEY2 = 16'h5555;
endpackage

// File: rtl/flcmd_addr_class.sv
module flcmd_addr_class
  import flcmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BOOT_BYTES  = 16384,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_mode,
  output logic              at_key1,
  output logic              at_key2,
  output logic              in_boot
);
  localparam longint SPAN = longint'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] BOOT_EDGE =
    BOOT_AT_TOP ? ADDR_W'(SPAN - longint'(BOOT_BYTES)) : ADDR_W'(BOOT_BYTES);

  logic [ADDR_W-1:0] byte_addr;
  logic [KEY_W-1:0]  key1, key2;

  assign key1      = byte_mode ? BYTE_KEY1 : WORD_KEY1;
  assign key2      = byte_mode ? BYTE_KEY2 : WORD_KEY2;
  assign at_key1   = (addr[KEY_W-1:0] == key1);
  assign at_key2   = (addr[KEY_W-1:0] == key2);
  assign byte_addr = byte_mode ? addr : {addr[ADDR_W-2:0], 1'b0};

  generate
    if (BOOT_AT_TOP) begin : g_top
      assign in_boot = (byte_addr >= BOOT_EDGE);
    end else begin : g_bottom
      assign in_boot = (byte_addr < BOOT_EDGE);
    end
  endgenerate
endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              boot_lock,
  input  logic              at_key1,
  input  logic              at_key2,
  input  logic              in_boot,
  output logic              prog_start,
  output logic              serase_start,
  output logic              cerase_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              autosel
);
  seq_state_t state_q, state_d;
  logic [7:0] code;
  logic go_prog, go_sect, go_chip, ident_set, take;

  assign code = wr_data[7:0];
  assign take = wr_valid && !busy;

  always_comb begin
    state_d   = state_q;
    go_prog   = 1'b0;
    go_sect   = 1'b0;
    go_chip   = 1'b0;
    ident_set = 1'b0;
    if (busy) begin
      state_d = ST_IDLE;
    end else if (wr_valid) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: if (code == CODE_UNLOCK_A && at_key1) state_d = ST_KEY1;
        ST_KEY1: if (code == CODE_UNLOCK_B && at_key2) state_d = ST_KEY2;
        ST_KEY2: if (at_key1) begin
          if (code == CODE_PROGRAM)    state_d = ST_PGM;
          else if (code == CODE_ERASE) state_d = ST_ERA3;
          else if (code == CODE_IDENT) ident_set = 1'b1;
        end
        ST_PGM:  go_prog = !(boot_lock && in_boot);
        ST_ERA3: if (code == CODE_UNLOCK_A && at_key1) state_d = ST_ERA4;
        ST_ERA4: if (code == CODE_UNLOCK_B && at_key2) state_d = ST_ERA5;
        ST_ERA5: begin
          if (code == CODE_CHIP && at_key1) go_chip = !boot_lock;
          else if (code == CODE_SECTOR)     go_sect = !(boot_lock && in_boot);
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      prog_start   <= 1'b0;
      serase_start <= 1'b0;
      cerase_start <= 1'b0;
      op_addr      <= '0;
      op_data      <= '0;
      autosel      <= 1'b0;
    end else begin
      state_q      <= state_d;
      prog_start   <= go_prog;
      serase_start <= go_sect;
      cerase_start <= go_chip;
      if (go_prog || go_sect || go_chip) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (ident_set)                         autosel <= 1'b1;
      else if (take && state_d == ST_IDLE)   autosel <= 1'b0;
    end
  end
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
  import flcmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int BOOT_BYTES  = 16384,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_mode,
  input  logic              busy,
  input  logic              boot_lock,
  output logic              prog_start,
  output logic              serase_start,
  output logic              cerase_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              autosel
);
  logic at_key1, at_key2, in_boot;

  flcmd_addr_class #(
    .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BOOT_AT_TOP(BOOT_AT_TOP)
  ) u_class (
    .addr(wr_addr), .byte_mode(byte_mode),
    .at_key1(at_key1), .at_key2(at_key2), .in_boot(in_boot)
  );

  flcmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .boot_lock(boot_lock),
    .at_key1(at_key1), .at_key2(at_key2), .in_boot(in_boot),
    .prog_start(prog_start), .serase_start(serase_start),
    .cerase_start(cerase_start), .op_addr(op_addr), .op_data(op_data),
    .autosel(autosel)
  );
endmodule

// File: rtl/flcmd_decoder_chk.sv
module flcmd_decoder_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              boot_lock,
  input logic              prog_start,
  input logic              serase_start,
  input logic              cerase_start,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic              autosel
);
  logic any_start;
  assign any_start = prog_start || serase_start || cerase_start;

  assert_single_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, serase_start, cerase_start}));

  assert_start_needs_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |-> $past(wr_valid && !busy));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !any_start);

  assert_prog_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

  assert_chip_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cerase_start |-> !$past(boot_lock));

  assert_ident_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autosel) |-> $past(wr_valid && !busy && wr_data[7:0] == 8'h90));
endmodule

bind flcmd_decoder flcmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .boot_lock(boot_lock),
  .prog_start(prog_start), .serase_start(serase_start),
  .cerase_start(cerase_start), .op_addr(op_addr), .op_data(op_data),
  .autosel(autosel)
);

// File: tb/flcmd_decoder_test.sv
`timescale 1ns/1ps
module flcmd_decoder_test;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int K_PROG = 1;
  localparam int K_SECT = 2;
  localparam int K_CHIP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic byte_mode = 1'b0;
  logic busy = 1'b0;
  logic boot_lock = 1'b0;
  logic prog_start, serase_start, cerase_start, autosel;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int            q_kind[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  string         q_tag[$];

  always #4 clk = ~clk;

  flcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
    .boot_lock(boot_lock), .prog_start(prog_start),
    .serase_start(serase_start), .cerase_start(cerase_start),
    .op_addr(op_addr), .op_data(op_data), .autosel(autosel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_op(input int kind, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
    q_kind.push_back(kind);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] key1();
    return byte_mode ? 19'h0AAAA : 19'h05555;
  endfunction
  function automatic logic [AW-1:0] key2();
    return byte_mode ? 19'h05555 : 19'h02AAA;
  endfunction

  task automatic head(input logic [7:0] c);
    wr(key1(), 16'h00AA);
    wr(key2(), 16'h0055);
    wr(key1(), {8'h00, c});
  endtask

  task automatic erase_head();
    head(8'h80);
    wr(key1(), 16'h00AA);
    wr(key2(), 16'h0055);
  endtask

  // Monitor: compares every start pulse against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      int k;
      n = int'(prog_start) + int'(serase_start) + int'(cerase_start);
      if (n > 1) check(1'b0, "R11 multiple pulses", n, 1);
      else if (n == 1) begin
        k = prog_start ? K_PROG : (serase_start ? K_SECT : K_CHIP);
        if (q_kind.size() == 0) begin
          check(1'b0, "R11 unexpected pulse", k, 0);
        end else begin
          int ek;
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          string tg;
          ek = q_kind.pop_front(); ea = q_addr.pop_front();
          ed = q_data.pop_front(); tg = q_tag.pop_front();
          check(k == ek, tg, k, ek);
          if (ek != K_CHIP) check(op_addr == ea, tg, int'(op_addr), int'(ea));
          if (ek == K_PROG) check(op_data == ed, tg, int'(op_data), int'(ed));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!prog_start && !serase_start && !cerase_start, "R1 pulses in reset",
          int'({prog_start, serase_start, cerase_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(autosel == 1'b0, "R1 autosel after reset", int'(autosel), 0);
    check(!prog_start && !serase_start && !cerase_start, "R1 pulses after reset",
          int'({prog_start, serase_start, cerase_start}), 0);

    // R2 word-mode program
    head(8'hA0);
    expect_op(K_PROG, 19'h12345, 16'hBEEF, "R2 word program");
    wr(19'h12345, 16'hBEEF);

    // R3 byte-mode program with byte keys
    byte_mode = 1'b1;
    head(8'hA0);
    expect_op(K_PROG, 19'h54321, 16'h005A, "R3 byte program");
    wr(19'h54321, 16'h005A);

    // R3 byte keys in word mode are not accepted: no pulse expected
    byte_mode = 1'b0;
    wr(19'h0AAAA, 16'h00AA);
    wr(19'h02AAA, 16'h0055);
    wr(19'h05555, 16'h00A0);
    wr(19'h10000, 16'h1111);

    // R4 sector erase, final code at an arbitrary address
    erase_head();
    expect_op(K_SECT, 19'h20400, 16'h0030, "R4 sector erase");
    wr(19'h20400, 16'h0030);

    // R5 chip erase
    erase_head();
    expect_op(K_CHIP, '0, '0, "R5 chip erase");
    wr(key1(), 16'h0010);

    // R6 autoselect entry, persistence mid-sequence, exits
    head(8'h90);
    check(autosel == 1'b1, "R6 autosel entered", int'(autosel), 1);
    wr(19'h00123, 16'h00F0);
    check(autosel == 1'b0, "R6 autosel cleared by F0", int'(autosel), 0);
    head(8'h90);
    wr(key1(), 16'h00AA);
    check(autosel == 1'b1, "R6 autosel held mid-sequence", int'(autosel), 1);
    wr(key2(), 16'h0055);
    wr(key1(), 16'h00A0);
    expect_op(K_PROG, 19'h03000, 16'h4321, "R6 program after autoselect");
    wr(19'h03000, 16'h4321);
    check(autosel == 1'b0, "R6 autosel cleared by program", int'(autosel), 0);

    // R7 mismatch at third and second beats; nothing fires
    head(8'hFF);
    wr(19'h11111, 16'h2222);
    wr(key1(), 16'h00AA);
    wr(key2(), 16'h0000);
    wr(key1(), 16'h00A0);
    wr(19'h11111, 16'h3333);
    head(8'hA0);
    expect_op(K_PROG, 19'h11111, 16'h4444, "R7 restart after mismatch");
    wr(19'h11111, 16'h4444);

    // R8 writes while busy are ignored
    @(negedge clk); busy = 1'b1;
    head(8'hA0);
    wr(19'h15000, 16'h5555);
    @(negedge clk); busy = 1'b0;
    // R8 busy in a gap abandons a partial sequence
    head(8'hA0);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    wr(19'h15000, 16'h6666);
    head(8'hA0);
    expect_op(K_PROG, 19'h15000, 16'h7777, "R8 program after busy");
    wr(19'h15000, 16'h7777);

    // R9 boot lock edges, word and byte mode
    boot_lock = 1'b1;
    head(8'hA0);
    wr(19'h01FFF, 16'h0101);
    head(8'hA0);
    expect_op(K_PROG, 19'h02000, 16'h0202, "R9 word just outside boot");
    wr(19'h02000, 16'h0202);
    byte_mode = 1'b1;
    head(8'hA0);
    wr(19'h03FFF, 16'h0003);
    head(8'hA0);
    expect_op(K_PROG, 19'h04000, 16'h0004, "R9 byte just outside boot");
    wr(19'h04000, 16'h0004);
    byte_mode = 1'b0;
    erase_head();
    wr(19'h00100, 16'h0030);
    erase_head();
    expect_op(K_SECT, 19'h08000, 16'h0030, "R9 sector outside boot");
    wr(19'h08000, 16'h0030);

    // R10 chip erase blocked by lock, then allowed
    erase_head();
    wr(key1(), 16'h0010);
    boot_lock = 1'b0;
    erase_head();
    expect_op(K_CHIP, '0, '0, "R10 chip erase unlocked");
    wr(key1(), 16'h0010);

    repeat (4) @(negedge clk);
    check(q_kind.size() == 0, "R11 all expected pulses seen", q_kind.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule